// File: doc/BRIEF.md
# Dual-Bank Configuration Image Validator

This block checks two equal-sized configuration images held back to back in a byte-wide memory and decides which one is valid and more recent. After a start pulse it reads every byte of image 0 and then image 1, one byte per clock. For each image it checks a signature byte, a folded 8-bit header sum and a 32-bit modulo-65521 running-sum body checksum, and it extracts a 32-bit generation counter.

When both scans are complete the block pulses `done` and presents the chosen image as a one-hot vector. It also reports both generation values and an error flag for the case where neither image is valid. The outputs are registered and hold until the next scan finishes. Typical use is at boot: a controller reads the chosen image's data before it rewrites the other bank. Rewriting images and erasing or programming flash are handled elsewhere.

Image header layout, all multi-byte fields big-endian: signature at offset 0, header sum at offset 1, a 16-bit length at offsets 2–3, the body checksum at offsets 4–7, and the generation at offsets 8–11. The body runs from offset 8 to the end of the image.

Top module: `nvv_image_check`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd_en`, `err` and `pick` are all low. A `start` sampled high while `busy` is low begins a scan. A `start` sampled while `busy` is high has no effect. `done` is high for exactly one cycle, on the clock edge that falls 2*BANK_BYTES+2 edges after the edge that sampled `start`.
- R2: During a scan, `mem_rd_en` is high for exactly 2*BANK_BYTES consecutive cycles. Over those cycles `mem_addr` counts up from 0 to 2*BANK_BYTES-1. Addresses below BANK_BYTES are image 0 and the rest are image 1. Read data is taken one cycle after the address.
- R3: An image is invalid when its byte at offset 0 differs from the parameter SIG.
- R4: The header sum starts with the value of the byte at offset 0 and adds the bytes at offsets 2 and 3. While the sum exceeds 255, it is replaced by its low 8 bits plus the bits above bit 7. An image is invalid when the result differs from the byte at offset 1.
- R5: The body checksum runs over offsets 8 to BANK_BYTES-1. It keeps a low sum that starts at 1 and a high sum that starts at 0. For each byte, the byte is added to the low sum, and then the new low sum is added to the high sum, both modulo 65521. An image is invalid unless the big-endian word at offsets 4–7 equals high*65536+low.
- R6: `gen0`/`gen1` carry the big-endian word at offsets 8–11 of a valid image, and 32'hFFFFFFFF for an invalid image.
- R7: `pick` bit 0 selects image 0 and bit 1 selects image 1. If exactly one image is valid, that image is selected. If both are valid, image 0 is selected only when its generation is strictly greater as an unsigned number; otherwise image 1 is selected.
- R8: When neither image is valid, `err` is 1 and `pick` is 2'b00. Otherwise `err` is 0.
- R9: `pick`, `err`, `gen0` and `gen1` stay unchanged from a `done` pulse until the next `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan when idle |
| busy | output | 1 | Scan in progress |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | $clog2(2*BANK_BYTES) | Memory byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| done | output | 1 | One-cycle result strobe |
| pick | output | 2 | One-hot selected image, zero when none |
| err | output | 1 | Neither image valid |
| gen0 | output | 32 | Image 0 generation, all ones if invalid |
| gen1 | output | 32 | Image 1 generation, all ones if invalid |

## Verification
The assertions assume that the memory returns data exactly one cycle after a sampled read and that the memory contents do not change during a scan. The bench writes images only while the block is idle, and its memory model has a fixed one-cycle read. The assertions also assume that `start` may arrive at any time. The stimulus therefore pulses `start` again in the middle of one scan, and the cycle on which `done` arrives shows whether that pulse was ignored.

// File: rtl/nvv_pkg.sv
package nvv_pkg;
  localparam logic [16:0] MODV = 17'd65521;

  // carry-fold a small header sum into 8 bits
  function automatic logic [7:0] fold8(input logic [9:0] s);
    logic [9:0] t;
    t = s;
    for (int i = 0; i < 3; i++) begin
      if (t > 10'd255) t = {2'b00, t[7:0]} + {8'b0, t[9:8]};
    end
    return t[7:0];
  endfunction
endpackage

// File: rtl/nvv_seq.sv
module nvv_seq #(
  parameter int BANK_BYTES = 512,
  localparam int OFF_W  = $clog2(BANK_BYTES),
  localparam int ADDR_W = $clog2(2*BANK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              rd_en,
  output logic [ADDR_W-1:0] addr,
  output logic              byte_v,
  output logic [OFF_W-1:0]  byte_off,
  output logic              fin,
  output logic              fin_bank
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(BANK_BYTES-1);

  logic             run_q, run_d, bank_q, bank_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             rv_q, rbank_q, fin_q, finb_q;
  logic [OFF_W-1:0] roff_q;

  assign busy = run_q | rv_q | fin_q;

  always_comb begin
    run_d  = run_q;
    bank_d = bank_q;
    off_d  = off_q;
    if (!busy && start) begin
      run_d  = 1'b1;
      bank_d = 1'b0;
      off_d  = '0;
    end else if (run_q) begin
      off_d = off_q + 1'b1;
      if (off_q == LAST) begin
        off_d = '0;
        if (bank_q) run_d  = 1'b0;
        else        bank_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      bank_q  <= 1'b0;
      off_q   <= '0;
      rv_q    <= 1'b0;
      roff_q  <= '0;
      rbank_q <= 1'b0;
      fin_q   <= 1'b0;
      finb_q  <= 1'b0;
    end else begin
      run_q   <= run_d;
      bank_q  <= bank_d;
      off_q   <= off_d;
      rv_q    <= run_q;
      roff_q  <= off_q;
      rbank_q <= bank_q;
      fin_q   <= rv_q && (roff_q == LAST);
      finb_q  <= rbank_q;
    end
  end

  assign rd_en    = run_q;
  assign addr     = bank_q ? (ADDR_W'(BANK_BYTES) + ADDR_W'(off_q)) : ADDR_W'(off_q);
  assign byte_v   = rv_q;
  assign byte_off = roff_q;
  assign fin      = fin_q;
  assign fin_bank = finb_q;

  // R2: consecutive reads step the address by one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (addr == $past(addr) + 1'b1));
  // R1: an accepted start begins reading at address zero
  a_r1_start_addr0: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (rd_en && addr == '0));
endmodule

// File: rtl/nvv_bank_eval.sv
module nvv_bank_eval
  import nvv_pkg::*;
#(
  parameter int         BANK_BYTES = 512,
  parameter logic [7:0] SIG        = 8'h5A,
  localparam int OFF_W = $clog2(BANK_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_v,
  input  logic [OFF_W-1:0] off,
  input  logic [7:0]       b,
  output logic             ok,
  output logic [31:0]      gen
);
  logic [7:0]  sig_q, sig_d, hck_q, hck_d;
  logic [9:0]  hs_q, hs_d;
  logic [31:0] ck_q, ck_d, gen_q, gen_d;
  logic [16:0] lo_q, lo_d, hi_q, hi_d;
  logic [16:0] lo_add, hi_add;

  always_comb begin
    sig_d = sig_q;
    hck_d = hck_q;
    hs_d  = hs_q;
    ck_d  = ck_q;
    gen_d = gen_q;
    lo_d  = lo_q;
    hi_d  = hi_q;
    lo_add = lo_q + {9'b0, b};
    if (lo_add >= MODV) lo_add = lo_add - MODV;
    hi_add = hi_q + lo_add;
    if (hi_add >= MODV) hi_add = hi_add - MODV;
    if (byte_v) begin
      if (off == OFF_W'(0)) begin
        sig_d = b;
        hs_d  = {2'b00, b};
        lo_d  = 17'd1;
        hi_d  = 17'd0;
      end else if (off == OFF_W'(1)) begin
        hck_d = b;
      end else if (off < OFF_W'(4)) begin
        hs_d = hs_q + {2'b00, b};
      end else if (off < OFF_W'(8)) begin
        ck_d = {ck_q[23:0], b};
      end else begin
        if (off < OFF_W'(12)) gen_d = {gen_q[23:0], b};
        lo_d = lo_add;
        hi_d = hi_add;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= '0;
      hck_q <= '0;
      hs_q  <= '0;
      ck_q  <= '0;
      gen_q <= '0;
      lo_q  <= 17'd1;
      hi_q  <= '0;
    end else if (byte_v) begin
      sig_q <= sig_d;
      hck_q <= hck_d;
      hs_q  <= hs_d;
      ck_q  <= ck_d;
      gen_q <= gen_d;
      lo_q  <= lo_d;
      hi_q  <= hi_d;
    end
  end

  assign ok  = (sig_q == SIG) && (fold8(hs_q) == hck_q) &&
               (ck_q == {hi_q[15:0], lo_q[15:0]});
  assign gen = gen_q;

  // R5: both running sums stay reduced below the modulus
  a_r5_sum_range: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q < MODV) && (hi_q < MODV));
  // R5: the low sum restarts at one on the first byte of an image
  a_r5_low_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_v && off == OFF_W'(0)) |=> (lo_q == 17'd1 && hi_q == 17'd0));
endmodule

// File: rtl/nvv_pick.sv
module nvv_pick (
  input  logic        ok0,
  input  logic [31:0] g0,
  input  logic        ok1,
  input  logic [31:0] g1,
  output logic [1:0]  pick,
  output logic        err,
  output logic [31:0] g0_out,
  output logic [31:0] g1_out
);
  always_comb begin
    pick = 2'b00;
    if (ok0 && ok1) pick = (g0 > g1) ? 2'b01 : 2'b10;
    else if (ok0)   pick = 2'b01;
    else if (ok1)   pick = 2'b10;
    err    = !(ok0 || ok1);
    g0_out = ok0 ? g0 : 32'hFFFF_FFFF;
    g1_out = ok1 ? g1 : 32'hFFFF_FFFF;
  end
endmodule

// File: rtl/nvv_image_check.sv
module nvv_image_check #(
  parameter int         BANK_BYTES = 512,
  parameter logic [7:0] SIG        = 8'h5A,
  localparam int OFF_W  = $clog2(BANK_BYTES),
  localparam int ADDR_W = $clog2(2*BANK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic [1:0]        pick,
  output logic              err,
  output logic [31:0]       gen0,
  output logic [31:0]       gen1
);
  logic             byte_v, fin, fin_bank, ev_ok;
  logic [OFF_W-1:0] byte_off;
  logic [31:0]      ev_gen;
  logic             r0_ok_q;
  logic [31:0]      r0_gen_q;
  logic [1:0]       pk_c;
  logic             er_c;
  logic [31:0]      g0_c, g1_c;
  logic             done_q;
  logic [1:0]       pick_q;
  logic             err_q;
  logic [31:0]      gen0_q, gen1_q;

  nvv_seq #(.BANK_BYTES(BANK_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .rd_en(mem_rd_en), .addr(mem_addr), .byte_v(byte_v),
    .byte_off(byte_off), .fin(fin), .fin_bank(fin_bank));

  nvv_bank_eval #(.BANK_BYTES(BANK_BYTES), .SIG(SIG)) u_eval (
    .clk(clk), .rst_n(rst_n), .byte_v(byte_v), .off(byte_off),
    .b(mem_rdata), .ok(ev_ok), .gen(ev_gen));

  nvv_pick u_pick (
    .ok0(r0_ok_q), .g0(r0_gen_q), .ok1(ev_ok), .g1(ev_gen),
    .pick(pk_c), .err(er_c), .g0_out(g0_c), .g1_out(g1_c));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0_ok_q  <= 1'b0;
      r0_gen_q <= '0;
    end else if (fin && !fin_bank) begin
      r0_ok_q  <= ev_ok;
      r0_gen_q <= ev_gen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      pick_q <= '0;
      err_q  <= 1'b0;
      gen0_q <= '0;
      gen1_q <= '0;
    end else begin
      done_q <= fin && fin_bank;
      if (fin && fin_bank) begin
        pick_q <= pk_c;
        err_q  <= er_c;
        gen0_q <= g0_c;
        gen1_q <= g1_c;
      end
    end
  end

  assign done = done_q;
  assign pick = pick_q;
  assign err  = err_q;
  assign gen0 = gen0_q;
  assign gen1 = gen1_q;

  // R1: done lasts a single cycle
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: at most one image is chosen
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0(pick));
  // R8: error exactly when no image is chosen
  a_r8_err_none: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err == (pick == 2'b00)));
  // R9: results hold between strobes
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(pick) && $stable(err) && $stable(gen0) && $stable(gen1)));
endmodule

// File: tb/nvv_image_check_test.sv
module nvv_image_check_test;
  localparam int PERIOD = 10;
  localparam int NB     = 512;
  localparam int AW     = $clog2(2*NB);
  localparam logic [7:0] SIGV = 8'h5A;

  logic          clk, rst_n, start, busy, mem_rd_en, done, err;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata;
  logic [1:0]    pick;
  logic [31:0]   gen0, gen1;
  logic [7:0]    mem [2*NB];

  int n_chk, n_fail, cyc, ndone, exp_addr, addr_bad;

  typedef struct {
    logic [1:0]  pick;
    logic        err;
    logic [31:0] g0, g1;
    int          due;
    string       tag;
  } exp_t;
  exp_t sb[$];

  nvv_image_check #(.BANK_BYTES(NB), .SIG(SIGV)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .pick(pick), .err(err), .gen0(gen0), .gen1(gen1));

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

  task automatic check(input bit good, input string req, input longint act, input longint expv);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic build(input int bk, input logic [31:0] g, input int bad, input int fill, output bit valid);
    int base, s;
    longint lo, hi;
    base = bk * NB;
    mem[base+0] = SIGV;
    mem[base+2] = 8'((NB >> 8) & 255);
    mem[base+3] = 8'(NB & 255);
    for (int k = 0; k < 4; k++) mem[base+8+k] = g[31-8*k -: 8];
    for (int i = 12; i < NB; i++)
      mem[base+i] = (fill != 0) ? 8'hFF : 8'((i * 13 + bk * 7 + g) & 255);
    lo = 1; hi = 0;
    for (int i = 8; i < NB; i++) begin
      lo = lo + mem[base+i];
      hi = hi + lo;
    end
    lo = lo % 65521; hi = hi % 65521;
    mem[base+4] = 8'(hi >> 8); mem[base+5] = 8'(hi & 255);
    mem[base+6] = 8'(lo >> 8); mem[base+7] = 8'(lo & 255);
    s = mem[base+0] + mem[base+2] + mem[base+3];
    while (s > 255) s = (s & 255) + (s >> 8);
    mem[base+1] = 8'(s);
    if (bad == 1) mem[base+0] = SIGV ^ 8'h01;
    if (bad == 2) mem[base+1] = mem[base+1] ^ 8'h10;
    if (bad == 3) mem[base+40] = mem[base+40] ^ 8'h04;
    valid = (bad == 0);
  endtask

  task automatic run_case(input logic [31:0] g0, input int b0, input logic [31:0] g1,
                          input int b1, input int fill, input bit repulse, input string tag);
    bit v0, v1;
    exp_t e;
    int target;
    build(0, g0, b0, fill, v0);
    build(1, g1, b1, fill, v1);
    e.g0 = v0 ? g0 : 32'hFFFF_FFFF;
    e.g1 = v1 ? g1 : 32'hFFFF_FFFF;
    e.err = !v0 && !v1;
    if (v0 && v1) e.pick = (g0 > g1) ? 2'b01 : 2'b10;
    else e.pick = v0 ? 2'b01 : (v1 ? 2'b10 : 2'b00);
    e.tag = tag;
    @(negedge clk);
    exp_addr = 0; addr_bad = 0;
    target = ndone + 1;
    e.due = cyc + 2*NB + 3;
    sb.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (repulse) begin
      repeat (100) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (ndone < target) @(negedge clk);
    repeat (4) @(negedge clk);
    check(pick == e.pick && err == e.err && gen0 == e.g0 && gen1 == e.g1,
          "R9 hold", {pick, err}, {e.pick, e.err});
  endtask

  // monitor: address tracking and result scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_rd_en) begin
        if (mem_addr != AW'(exp_addr)) addr_bad++;
        exp_addr++;
      end
      if (rst_n && done) begin
        exp_t e;
        e = sb.pop_front();
        check(cyc == e.due, "R1 done timing", cyc, e.due);
        check(exp_addr == 2*NB && addr_bad == 0, "R2 address sweep", exp_addr, 2*NB);
        check(pick == e.pick, {e.tag, " R7 pick"}, pick, e.pick);
        check(err == e.err, {e.tag, " R8 err"}, err, e.err);
        check(gen0 == e.g0, {e.tag, " R6 gen0"}, gen0, e.g0);
        check(gen1 == e.g1, {e.tag, " R6 gen1"}, gen1, e.g1);
        ndone++;
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; ndone = 0; exp_addr = 0; addr_bad = 0;
    start = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_rd_en && !err && pick == 2'b00, "R1 reset state",
          {busy, done, mem_rd_en, err, pick}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_case(32'd5, 0, 32'd3, 0, 0, 1'b0, "R7 newer image 0");
    run_case(32'd3, 0, 32'd7, 0, 0, 1'b0, "R7 newer image 1");
    run_case(32'd9, 0, 32'd9, 0, 0, 1'b0, "R7 tie");
    run_case(32'd20, 1, 32'd2, 0, 0, 1'b0, "R3 bad signature");
    run_case(32'd0, 0, 32'd8, 2, 0, 1'b0, "R4 bad header sum");
    run_case(32'd4, 3, 32'd6, 1, 0, 1'b0, "R5 bad body / R8 none");
    run_case(32'h8000_0000, 0, 32'h7FFF_FFFF, 0, 0, 1'b1, "R1 restart ignored R7 unsigned");
    run_case(32'd11, 0, 32'd12, 3, 1, 1'b0, "R5 saturated body");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule